// File: doc/BRIEF.md
# Prescaled Watchdog Timer

A watchdog peripheral on a simple strobed register bus. A 16-bit live counter counts down one step per tick and is reloaded by software. A program that stops writing to it lets the counter expire. The tick comes from two stages in series. The first is an 8-bit programmable prescaler. The second is a post-divider that divides by 16, 32, 64 or 128. The tick period is therefore (prescale + 1) × post-divide input clocks.

On expiry the counter reloads from a separate reload register on the same tick. Depending on two independent enable bits, expiry also raises a sticky interrupt level, a reset-request pulse, or both. Software feeds the watchdog by writing the live count register directly. A count write also restarts the tick phase. To start the timer, software writes the reload register, then the count register, then the control register with the enable bit set. To stop it, software clears the enable and reset-enable bits.

Register map (word address on `addr_i`): 0 = control, 1 = reload, 2 = live count, 3 = unused. Control fields:

| Bits | Field |
|------|-------|
| [0] | run enable |
| [1] | interrupt enable |
| [2] | reset enable |
| [4:3] | post-divider select |
| [5] | interrupt clear, write 1; reads 0 |
| [15:8] | prescale value minus one |

Top module: `wdog_timer`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0 and `rst_req_o` is 0.
- R2: Reads return the data combinationally while `rd_en_i` is high. Control reads back its fields at the positions given above, with bit 5 and bits [7:6] reading 0. Address 3 reads 0.
- R3: While enabled, the live count drops by one every (P+1)×D input clocks. P is control[15:8]. D is 16, 32, 64 or 128 for control[4:3] = 00, 01, 10, 11. The first tick falls D×(P+1) clocks after the edge that sets the enable bit.
- R4: A tick that finds the count at 0 reloads it from the reload register on that same edge and counts as an expiry. With reload value N, expiries therefore repeat every N+1 ticks.
- R5: With control[1] set, an expiry sets `irq_o` on the expiry edge. It stays set until a control write with bit 5 = 1, and an expiry on the same edge as that write wins over the clear.
- R6: With control[2] set, an expiry drives `rst_req_o` high for exactly 128 input clocks, starting on the expiry edge. An expiry that comes while the pulse is running does not restart it.
- R7: A write to the count register loads the live counter on the next edge and restarts both divider stages from zero. Such a write is the keepalive, and regular writes prevent any expiry.
- R8: While control[0] is 0, the live count and both divider stages hold, and no expiry occurs.
- R9: With control[1] = 0, expiry leaves `irq_o` low. With control[2] = 0, expiry leaves `rst_req_o` low.
- R10: Writing the reload register does not change the live count, and writing the count register does not change the reload register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer and bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, 0 when not reading |
| irq_o | output | 1 | Expiry interrupt level |
| rst_req_o | output | 1 | Expiry reset-request pulse |

## Verification
Read data is combinational, so register and count values are sampled 2 ns after the edge in the same cycle the read strobe is raised. Every timed result is counted in edges from the edge that takes the enabling control write or the feeding count write. The first decrement is due at edge D×(P+1), and the first expiry at edge (N+1)×D×(P+1). The interrupt and the start of the reset request appear on that expiry edge itself. The bench samples each output one edge before its due edge and again on it, and checks that the reset request is still high 127 edges after it rises and low at edge 128.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_RELOAD = 2'd1,
    ADDR_COUNT  = 2'd2,
    ADDR_NONE   = 2'd3
  } wdog_addr_e;

  localparam int unsigned BIT_EN      = 0;
  localparam int unsigned BIT_IRQ_EN  = 1;
  localparam int unsigned BIT_RST_EN  = 2;
  localparam int unsigned SEL_LSB     = 3;
  localparam int unsigned BIT_IRQ_CLR = 5;
  localparam int unsigned PRE_LSB     = 8;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  output logic              en_o,
  output logic              irq_en_o,
  output logic              rst_en_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [PRE_W-1:0]  presc_o,
  output logic [DATA_W-1:0] reload_o,
  output logic              cnt_ld_o,
  output logic              irq_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  wdog_addr_e addr;
  logic       wr_ctrl, wr_reload;
  logic [DATA_W-1:0] ctrl_rd;

  assign addr      = wdog_addr_e'(addr_i);
  assign wr_ctrl   = wr_en_i && (addr == ADDR_CTRL);
  assign wr_reload = wr_en_i && (addr == ADDR_RELOAD);
  assign cnt_ld_o  = wr_en_i && (addr == ADDR_COUNT);
  assign irq_clr_o = wr_ctrl && wdata_i[BIT_IRQ_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= 1'b0;
      irq_en_o <= 1'b0;
      rst_en_o <= 1'b0;
      sel_o    <= '0;
      presc_o  <= '0;
      reload_o <= '0;
    end else begin
      if (wr_ctrl) begin
        en_o     <= wdata_i[BIT_EN];
        irq_en_o <= wdata_i[BIT_IRQ_EN];
        rst_en_o <= wdata_i[BIT_RST_EN];
        sel_o    <= wdata_i[SEL_LSB +: SEL_W];
        presc_o  <= wdata_i[PRE_LSB +: PRE_W];
      end
      if (wr_reload) reload_o <= wdata_i;
    end
  end

  always_comb begin
    ctrl_rd                     = '0;
    ctrl_rd[BIT_EN]             = en_o;
    ctrl_rd[BIT_IRQ_EN]         = irq_en_o;
    ctrl_rd[BIT_RST_EN]         = rst_en_o;
    ctrl_rd[SEL_LSB +: SEL_W]   = sel_o;
    ctrl_rd[PRE_LSB +: PRE_W]   = presc_o;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (addr)
        ADDR_CTRL:   rdata_o = ctrl_rd;
        ADDR_RELOAD: rdata_o = reload_o;
        ADDR_COUNT:  rdata_o = cnt_i;
        default:     rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_divider.sv
module wdog_divider #(
  parameter int unsigned PRE_W          = 8,
  parameter int unsigned SEL_W          = 2,
  parameter int unsigned POST_BASE_LOG2 = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] presc_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned NUM_SEL = 1 << SEL_W;
  localparam int unsigned POST_W  = POST_BASE_LOG2 + NUM_SEL - 1;

  logic [PRE_W-1:0]  pre_q;
  logic [POST_W-1:0] post_q;
  logic [POST_W-1:0] lim_tbl [NUM_SEL];
  logic [POST_W-1:0] post_lim;
  logic              pre_hit, post_hit;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_lim
    assign lim_tbl[g] = POST_W'((1 << (POST_BASE_LOG2 + g)) - 1);
  end

  assign post_lim = lim_tbl[sel_i];
  assign pre_hit  = (pre_q == presc_i);
  assign post_hit = (post_q == post_lim);
  assign tick_o   = en_i && pre_hit && post_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      post_q <= '0;
    end else if (clr_i) begin
      pre_q  <= '0;
      post_q <= '0;
    end else if (en_i) begin
      if (pre_hit) begin
        pre_q  <= '0;
        post_q <= post_hit ? '0 : post_q + 1'b1;
      end else begin
        pre_q  <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic at_zero;
  assign at_zero  = (cnt_o == '0);
  // a keepalive on the same edge cancels the expiry
  assign expire_o = tick_i && at_zero && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (load_i)  cnt_o <= load_val_i;
    else if (tick_i)  cnt_o <= at_zero ? reload_i : cnt_o - 1'b1;
  end
endmodule

// File: rtl/wdog_expiry.sv
module wdog_expiry #(
  parameter int unsigned RST_CYC = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic irq_en_i,
  input  logic rst_en_i,
  input  logic irq_clr_i,
  output logic irq_o,
  output logic rst_req_o
);
  localparam int unsigned RW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
  localparam logic [RW-1:0] LAST = RW'(RST_CYC - 1);

  logic [RW-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   irq_o <= 1'b0;
    else if (expire_i && irq_en_i) irq_o <= 1'b1;
    else if (irq_clr_i)            irq_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o <= 1'b0;
      len_q     <= '0;
    end else if (rst_req_o) begin
      if (len_q == LAST) rst_req_o <= 1'b0;
      len_q <= len_q + 1'b1;
    end else if (expire_i && rst_en_i) begin
      rst_req_o <= 1'b1;
      len_q     <= '0;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W          = 16,
  parameter int unsigned PRE_W          = 8,
  parameter int unsigned SEL_W          = 2,
  parameter int unsigned POST_BASE_LOG2 = 4,
  parameter int unsigned RST_CYC        = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  logic             ctrl_en, ctrl_irq_en, ctrl_rst_en;
  logic [SEL_W-1:0] ctrl_sel;
  logic [PRE_W-1:0] ctrl_presc;
  logic [CNT_W-1:0] reload_q, cnt_q;
  logic             cnt_ld, irq_clr, tick, expire;

  wdog_regs #(.DATA_W(CNT_W), .PRE_W(PRE_W), .SEL_W(SEL_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cnt_i     (cnt_q),
    .en_o      (ctrl_en),
    .irq_en_o  (ctrl_irq_en),
    .rst_en_o  (ctrl_rst_en),
    .sel_o     (ctrl_sel),
    .presc_o   (ctrl_presc),
    .reload_o  (reload_q),
    .cnt_ld_o  (cnt_ld),
    .irq_clr_o (irq_clr),
    .rdata_o   (rdata_o)
  );

  wdog_divider #(.PRE_W(PRE_W), .SEL_W(SEL_W), .POST_BASE_LOG2(POST_BASE_LOG2)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl_en),
    .clr_i   (cnt_ld),
    .presc_i (ctrl_presc),
    .sel_i   (ctrl_sel),
    .tick_o  (tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (cnt_ld),
    .load_val_i (wdata_i),
    .reload_i   (reload_q),
    .cnt_o      (cnt_q),
    .expire_o   (expire)
  );

  wdog_expiry #(.RST_CYC(RST_CYC)) u_exp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .expire_i  (expire),
    .irq_en_i  (ctrl_irq_en),
    .rst_en_i  (ctrl_rst_en),
    .irq_clr_i (irq_clr),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned RST_CYC = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input logic             clr_bit_i,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             en_i,
  input logic             irq_en_i,
  input logic             rst_en_i,
  input logic [CNT_W-1:0] cnt_i
);
  logic [15:0] hi_len;
  logic        ctrl_clr, cnt_wr;

  assign ctrl_clr = wr_en_i && (addr_i == 2'd0) && clr_bit_i;
  assign cnt_wr   = wr_en_i && (addr_i == 2'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_len <= '0;
    else if (rst_req_o) hi_len <= hi_len + 1'b1;
    else                hi_len <= '0;
  end

  p_rst_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> (hi_len == 16'(RST_CYC)));

  p_rst_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (hi_len < 16'(RST_CYC)));

  p_irq_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ctrl_clr) |=> irq_o);

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en_i && !irq_o) |=> !irq_o);

  p_rst_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_en_i && !rst_req_o) |=> !rst_req_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_wr) |=> $stable(cnt_i));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_wr && (cnt_i != '0)) |=> (cnt_i == $past(cnt_i)) || (cnt_i == $past(cnt_i) - 1'b1));
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .clr_bit_i (wdata_i[wdog_pkg::BIT_IRQ_CLR]),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o),
  .en_i      (ctrl_en),
  .irq_en_i  (ctrl_irq_en),
  .rst_en_i  (ctrl_rst_en),
  .cnt_i     (cnt_q)
);

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o, rst_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  wdog_timer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  // {prescale[31:24], select[23:16], count[15:0]}
  localparam logic [31:0] VEC [6] = '{
    {8'd0,   8'd0, 16'd3},
    {8'd0,   8'd1, 16'd1},
    {8'd2,   8'd2, 16'd0},
    {8'd1,   8'd3, 16'd1},
    {8'd4,   8'd0, 16'd7},
    {8'd255, 8'd3, 16'd0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // write lands on the returned edge; returns 1 ns after it
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1 wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_en_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    rd_en_i = 1'b0;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk_i);
    #2;
  endtask

  initial begin
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, v2;
    int k;
    #3;
    chk("R1 irq", {15'd0, irq_o}, 16'd0);
    chk("R1 rst_req", {15'd0, rst_req_o}, 16'd0);
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), v);
      chk("R1 reg", v, 16'd0);
    end

    // R2 readback
    wr(2'd0, 16'h5A1E); rd(2'd0, v); chk("R2 ctrl", v, 16'h5A1E);
    wr(2'd0, 16'h00E0); rd(2'd0, v); chk("R2 clr reads 0", v, 16'h0000);
    rd(2'd3, v); chk("R2 addr3", v, 16'h0000);
    // R10 separation
    wr(2'd1, 16'h1234); rd(2'd1, v); chk("R10 reload", v, 16'h1234);
    rd(2'd2, v); chk("R10 count untouched", v, 16'h0000);
    wr(2'd2, 16'hBEEF); rd(2'd2, v); chk("R7 count load", v, 16'hBEEF);
    rd(2'd1, v); chk("R10 reload untouched", v, 16'h1234);

    // vector table: R3 period per prescale/select, R5 irq, R9 no rst
    for (int i = 0; i < 6; i++) begin
      logic [7:0] p, s;
      logic [15:0] n;
      p = VEC[i][31:24]; s = VEC[i][23:16]; n = VEC[i][15:0];
      k = (int'(n) + 1) * (int'(p) + 1) * (16 << s);
      wr(2'd0, 16'h0020);
      wr(2'd1, n);
      wr(2'd2, n);
      wr(2'd0, {p, 3'b000, s[1:0], 3'b011});
      edges(k - 1);
      chk("R3 no early expiry", {15'd0, irq_o}, 16'd0);
      edges(1);
      chk("R3 R5 expiry edge", {15'd0, irq_o}, 16'd1);
      chk("R9 rst gated", {15'd0, rst_req_o}, 16'd0);
    end

    // R3 decrement timing, then R8 hold
    wr(2'd0, 16'h0020);
    wr(2'd1, 16'h0010);
    wr(2'd2, 16'd5);
    wr(2'd0, 16'h0001);
    edges(15); rd(2'd2, v); chk("R3 before tick", v, 16'd5);
    edges(1);  rd(2'd2, v); chk("R3 after tick", v, 16'd4);
    wr(2'd0, 16'h0000);
    rd(2'd2, v);
    edges(300); rd(2'd2, v2); chk("R8 count holds", v2, v);
    chk("R8 no irq", {15'd0, irq_o}, 16'd0);

    // R4 reload on expiry, R5 clear and re-expiry
    wr(2'd1, 16'd2);
    wr(2'd2, 16'd0);
    wr(2'd0, 16'h0003);
    edges(16); rd(2'd2, v); chk("R4 reload same tick", v, 16'd2);
    chk("R5 irq set", {15'd0, irq_o}, 16'd1);
    edges(5);
    chk("R5 irq sticky", {15'd0, irq_o}, 16'd1);
    wr(2'd0, 16'h0023);
    #1 chk("R5 irq cleared", {15'd0, irq_o}, 16'd0);
    edges(41);
    chk("R4 no early re-expiry", {15'd0, irq_o}, 16'd0);
    edges(1);
    chk("R4 re-expiry after N+1 ticks", {15'd0, irq_o}, 16'd1);

    // R6 reset pulse, R9 irq gated
    wr(2'd0, 16'h0020);
    wr(2'd1, 16'h00FF);
    wr(2'd2, 16'd0);
    wr(2'd0, 16'h0005);
    edges(15); chk("R6 not yet", {15'd0, rst_req_o}, 16'd0);
    edges(1);  chk("R6 rises", {15'd0, rst_req_o}, 16'd1);
    chk("R9 irq gated", {15'd0, irq_o}, 16'd0);
    edges(127); chk("R6 still high", {15'd0, rst_req_o}, 16'd1);
    edges(1);   chk("R6 falls at 128", {15'd0, rst_req_o}, 16'd0);

    // R7 keepalive
    wr(2'd0, 16'h0020);
    wr(2'd2, 16'd2);
    wr(2'd0, 16'h0007);
    for (int i = 0; i < 6; i++) begin
      edges(38);
      wr(2'd2, 16'd2);
    end
    chk("R7 fed irq", {15'd0, irq_o}, 16'd0);
    chk("R7 fed rst", {15'd0, rst_req_o}, 16'd0);
    edges(47);
    chk("R7 phase restart", {15'd0, irq_o}, 16'd0);
    edges(1);
    chk("R7 starve expiry", {15'd0, irq_o}, 16'd1);
    chk("R7 starve reset", {15'd0, rst_req_o}, 16'd1);
    wr(2'd0, 16'h0020);
    edges(140);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule